// File: doc/BRIEF.md
# Multi-Format Audio Serial Port

This block moves stereo audio between a parallel sample interface and a single serial data line in each direction. An external master supplies the bit clock and the left/right (word) clock. The block samples both in its own system clock domain, works out where each bit falls inside the frame, and drives one output bit per bit clock. A matching receive path rebuilds parallel words from the incoming line.

Five framings are available. Three follow the level of the left/right clock: I2S, left-justified and right-justified. The fourth is a DSP style framing driven by a one-bit-clock frame pulse. The fifth is a packed framing that carries four channel pairs in a 256-bit-clock frame. A width selector picks 24, 20 or 16 significant bits per word. Right-justified placement depends on this width. The transmit side takes a new set of words at each frame start and uses them for the whole frame. The receive side publishes the words of a completed frame at the next frame start.

Top module: `audio_serial_port`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `sd_out` is 0, `rx_strobe` is 0 and both receive word buses are all zeros.
- R2: With `fmt_sel` = 000 (I2S), half-frames are 32 bit clocks long. Left data is sent while the word clock is low and right data while it is high. The MSB goes out on the second bit clock after each word-clock transition.
- R3: With `fmt_sel` = 001 (left-justified), the MSB goes out on the first bit clock of each 32-clock half-frame, that is, the bit clock on which the word clock changes.
- R4: With `fmt_sel` = 010 (right-justified), a word of W bits starts at bit clock 32-W of its half-frame, so its LSB is on the last bit clock of that half-frame.
- R5: With `fmt_sel` = 011 (DSP), a frame starts when the word clock goes high for one bit clock. The left MSB goes out on the next bit clock, and the right word follows directly after the left LSB.
- R6: With `fmt_sel` = 100 (packed), a frame is 256 bit clocks. Each half-frame (word clock low for left, high for right) holds four 32-clock slots. Slots go out in index order 0..3, slot k taking bits [24k+23:24k] of the word bus, MSB at the start of the slot.
- R7: `wlen_sel` 00 and 11 select 24 bits, 01 selects 20 bits and 10 selects 16 bits. The W most significant bits of each 24-bit word are the ones sent.
- R8: Bit positions that no word occupies, including those after the LSB, drive `sd_out` to 0.
- R9: `sd_out` changes only after a falling bit-clock edge and holds through the high phase of the bit clock. Receive bits are taken on the rising edge.
- R10: The receive path places each bit it takes from `sd_in` at the position the transmit rules give. At the next frame start it presents the completed words, with bits beyond the width reading 0, together with a single-cycle `rx_strobe`.
- R11: Transmit words are taken at frame start. A change of `tx_left` or `tx_right` in the middle of a frame does not alter the bits sent in that frame.
- R12: The unassigned `fmt_sel` codes 101, 110 and 111 behave as I2S.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must run well above twice the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_sel | input | 3 | Framing select (000 I2S, 001 LJ, 010 RJ, 011 DSP, 100 packed) |
| wlen_sel | input | 2 | Word width select (00/11 = 24, 01 = 20, 10 = 16) |
| bclk_in | input | 1 | External bit clock |
| lrclk_in | input | 1 | External left/right clock or frame pulse |
| tx_left | input | 96 | Left words, slot k at bits [24k+23:24k] |
| tx_right | input | 96 | Right words, same layout |
| sd_out | output | 1 | Serial transmit data |
| sd_in | input | 1 | Serial receive data |
| rx_left | output | 96 | Received left words, same layout |
| rx_right | output | 96 | Received right words, same layout |
| rx_strobe | output | 1 | One-cycle pulse when the receive words update |

## Verification
Checks that hold on every cycle cover these behaviours: the output bit moves only in the cycle after a detected falling bit-clock edge, unoccupied positions drive zero, and the receive strobe is a lone pulse tied to a frame start with the receive words frozen between pulses. Other behaviour shows only in the bench's scenarios: that each framing puts the MSB on the right bit clock, that right-justified words end at the half-frame edge for every width, that packed slots come out in order, that mid-frame input changes are ignored, and that a loopback reproduces the masked words.

// File: rtl/asp_pkg.sv
// Shared types and helpers for the audio serial port.
// Assumes words are 24 bits wide, with the MSB at bit 23.
package asp_pkg;

    localparam int SAMPLE_W = 24;

    // framing codes; codes not listed here fall back to I2S
    typedef enum logic [2:0] {
        FMT_I2S  = 3'b000,
        FMT_LJ   = 3'b001,
        FMT_RJ   = 3'b010,
        FMT_DSP  = 3'b011,
        FMT_PACK = 3'b100
    } fmt_e;

    // decode the width select into a number of significant bits
    function automatic logic [5:0] width_of(input logic [1:0] code);
        case (code)
            2'b01:   return 6'd20;
            2'b10:   return 6'd16;
            default: return 6'd24;
        endcase
    endfunction

endpackage

// File: rtl/asp_edge_sync.sv
// Brings the external bit clock and word clock into the system clock
// domain and produces one-cycle strobes for the bit-clock edges.
// Assumes both clocks are at least three system clocks per level,
// and that the word clock changes together with a falling bit clock.
module asp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_in,
    input  logic lrclk_in,
    output logic bclk_fall,
    output logic bclk_rise,
    output logic lr_lvl
);

    logic [STAGES-1:0] bsync;
    logic [STAGES-1:0] lsync;
    logic              b_last;

    // synchronizer chains plus a delayed copy used for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bsync  <= '0;
            lsync  <= '0;
            b_last <= 1'b0;
        end else begin
            bsync  <= {bsync[STAGES-2:0], bclk_in};
            lsync  <= {lsync[STAGES-2:0], lrclk_in};
            b_last <= bsync[STAGES-1];
        end
    end

    assign bclk_fall = b_last & ~bsync[STAGES-1];
    assign bclk_rise = ~b_last & bsync[STAGES-1];
    assign lr_lvl    = lsync[STAGES-1];

endmodule

// File: rtl/asp_frame_ctr.sv
// Tracks the bit position inside the current half-frame (or the whole
// frame in DSP framing) and flags the frame start.
// Updates only on a falling bit-clock strobe. The next-state values
// are exported so the transmit side can act in the same cycle.
module asp_frame_ctr #(
    parameter int POS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_fall,
    input  logic             lr_lvl,
    input  logic [2:0]       fmt_sel,
    output logic [POS_W-1:0] pos_q,
    output logic [POS_W-1:0] pos_nx,
    output logic             half_q,
    output logic             frame_start
);
    import asp_pkg::*;

    localparam logic [POS_W-1:0] POS_MAX = '1;

    logic is_dsp;
    logic lr_rise;
    logic ref_edge;

    assign is_dsp   = (fmt_sel == FMT_DSP);
    assign lr_rise  = lr_lvl & ~half_q;
    // position resets at every word-clock edge, or only at the pulse for DSP
    assign ref_edge = is_dsp ? lr_rise : (lr_lvl != half_q);

    // next position: restart at the reference edge, else count and saturate
    always_comb begin
        if (ref_edge)
            pos_nx = '0;
        else if (pos_q == POS_MAX)
            pos_nx = pos_q;
        else
            pos_nx = pos_q + 1'b1;
    end

    // a frame opens at the left half (word clock falls) or at the DSP pulse
    assign frame_start = bclk_fall & (is_dsp ? lr_rise : (half_q & ~lr_lvl));

    // position and word-clock level captured at each falling bit clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= '0;
            half_q <= 1'b0;
        end else if (bclk_fall) begin
            pos_q  <= pos_nx;
            half_q <= lr_lvl;
        end
    end

endmodule

// File: rtl/asp_slot_map.sv
// Combinational map from a bit position to the word bit carried there.
// Gives a hit flag, the channel (0 left, 1 right), the slot and the bit
// index inside the 24-bit word. Shared by the transmit and receive paths.
module asp_slot_map #(
    parameter int SAMPLE_W       = 24,
    parameter int SLOTS          = 4,
    parameter int HALF_BCLK      = 32,
    parameter int PACK_HALF_BCLK = 128,
    parameter int POS_W          = 8,
    localparam int SLOT_W        = $clog2(SLOTS),
    localparam int IDX_W         = $clog2(SAMPLE_W)
) (
    input  logic [2:0]        fmt_sel,
    input  logic [1:0]        wlen_sel,
    input  logic [POS_W-1:0]  pos,
    input  logic              half,
    output logic              hit,
    output logic              chan,
    output logic [SLOT_W-1:0] slot,
    output logic [IDX_W-1:0]  bit_idx
);
    import asp_pkg::*;

    localparam int SLOT_BITS = PACK_HALF_BCLK / SLOTS;
    localparam int SLOT_SH   = $clog2(SLOT_BITS);

    int p;
    int w;
    int off;

    // placement rules for every framing
    always_comb begin
        p    = int'(pos);
        w    = int'(width_of(wlen_sel));
        hit  = 1'b0;
        chan = half;
        slot = '0;
        off  = 0;
        case (fmt_e'(fmt_sel))
            FMT_LJ: begin
                off = p;
                hit = (p < w);
            end
            FMT_RJ: begin
                off = p - (HALF_BCLK - w);
                hit = (p >= HALF_BCLK - w) && (p < HALF_BCLK);
            end
            FMT_DSP: begin
                chan = (p - 1 >= w);
                off  = chan ? (p - 1 - w) : (p - 1);
                hit  = (p >= 1) && (p - 1 < 2 * w);
            end
            FMT_PACK: begin
                slot = pos[SLOT_SH +: SLOT_W];
                off  = p % SLOT_BITS;
                hit  = (off < w) && (p < PACK_HALF_BCLK);
            end
            default: begin
                off = p - 1;
                hit = (p >= 1) && (p - 1 < w);
            end
        endcase
        bit_idx = hit ? IDX_W'(SAMPLE_W - 1 - off) : '0;
    end

endmodule

// File: rtl/asp_tx.sv
// Transmit path: takes the word buses at frame start and drives the
// mapped bit after each falling bit clock, or zero where no word sits.
// A bypass lets the first bit of a frame come straight from the inputs.
module asp_tx #(
    parameter int SAMPLE_W = 24,
    parameter int SLOTS    = 4,
    localparam int SLOT_W  = $clog2(SLOTS),
    localparam int IDX_W   = $clog2(SAMPLE_W),
    localparam int BUS_W   = SLOTS * SAMPLE_W,
    localparam int FI_W    = $clog2(BUS_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_fall,
    input  logic              frame_start,
    input  logic              hit,
    input  logic              chan,
    input  logic [SLOT_W-1:0] slot,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic [BUS_W-1:0]  tx_left,
    input  logic [BUS_W-1:0]  tx_right,
    output logic              sd_out
);

    logic [BUS_W-1:0] hold_l;
    logic [BUS_W-1:0] hold_r;
    logic [BUS_W-1:0] word_sel;
    logic [FI_W-1:0]  flat;

    // choose the channel bus, bypassing the holding register at frame start
    always_comb begin
        if (chan)
            word_sel = frame_start ? tx_right : hold_r;
        else
            word_sel = frame_start ? tx_left : hold_l;
        flat = FI_W'(int'(slot) * SAMPLE_W + int'(bit_idx));
    end

    // take the words once per frame and shift out one bit per bit clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_l <= '0;
            hold_r <= '0;
            sd_out <= 1'b0;
        end else begin
            if (frame_start) begin
                hold_l <= tx_left;
                hold_r <= tx_right;
            end
            if (bclk_fall)
                sd_out <= hit ? word_sel[flat] : 1'b0;
        end
    end

endmodule

// File: rtl/asp_rx.sv
// Receive path: writes each mapped bit taken on a rising bit clock into
// an accumulator, then moves the finished frame to the outputs at the
// next frame start with a one-cycle strobe. Publishing begins only
// after one full frame has been seen.
module asp_rx #(
    parameter int SAMPLE_W = 24,
    parameter int SLOTS    = 4,
    localparam int SLOT_W  = $clog2(SLOTS),
    localparam int IDX_W   = $clog2(SAMPLE_W),
    localparam int BUS_W   = SLOTS * SAMPLE_W,
    localparam int FI_W    = $clog2(BUS_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_rise,
    input  logic              frame_start,
    input  logic              hit,
    input  logic              chan,
    input  logic [SLOT_W-1:0] slot,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic              sd_in,
    output logic [BUS_W-1:0]  rx_left,
    output logic [BUS_W-1:0]  rx_right,
    output logic              rx_strobe
);

    logic [BUS_W-1:0] acc_l;
    logic [BUS_W-1:0] acc_r;
    logic [FI_W-1:0]  flat;
    logic             seen;

    assign flat = FI_W'(int'(slot) * SAMPLE_W + int'(bit_idx));

    // collect bits during a frame and hand the result over at the next start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_l     <= '0;
            acc_r     <= '0;
            rx_left   <= '0;
            rx_right  <= '0;
            rx_strobe <= 1'b0;
            seen      <= 1'b0;
        end else begin
            rx_strobe <= 1'b0;
            if (frame_start) begin
                if (seen) begin
                    rx_left   <= acc_l;
                    rx_right  <= acc_r;
                    rx_strobe <= 1'b1;
                end
                seen  <= 1'b1;
                acc_l <= '0;
                acc_r <= '0;
            end else if (bclk_rise && hit) begin
                if (chan)
                    acc_r[flat] <= sd_in;
                else
                    acc_l[flat] <= sd_in;
            end
        end
    end

endmodule

// File: rtl/audio_serial_port.sv
// Multi-format audio serial port, top level. Slave to an external bit
// clock and word clock that it samples with the system clock. Two copies
// of the slot map serve transmit (next position) and receive (current
// position). Assumes 64 bit clocks per frame in the level-based and DSP
// framings, and 256 in packed framing.
module audio_serial_port #(
    parameter int SAMPLE_W       = asp_pkg::SAMPLE_W,
    parameter int SLOTS          = 4,
    parameter int HALF_BCLK      = 32,
    parameter int PACK_HALF_BCLK = 128,
    parameter int SYNC_STAGES    = 2,
    localparam int BUS_W         = SLOTS * SAMPLE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       fmt_sel,
    input  logic [1:0]       wlen_sel,
    input  logic             bclk_in,
    input  logic             lrclk_in,
    input  logic [BUS_W-1:0] tx_left,
    input  logic [BUS_W-1:0] tx_right,
    output logic             sd_out,
    input  logic             sd_in,
    output logic [BUS_W-1:0] rx_left,
    output logic [BUS_W-1:0] rx_right,
    output logic             rx_strobe
);

    localparam int POS_W  = $clog2(2 * PACK_HALF_BCLK);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int IDX_W  = $clog2(SAMPLE_W);

    logic              bclk_fall;
    logic              bclk_rise;
    logic              lr_lvl;
    logic [POS_W-1:0]  pos_q;
    logic [POS_W-1:0]  pos_nx;
    logic              half_q;
    logic              frame_start;
    logic              tx_hit;
    logic              tx_chan;
    logic [SLOT_W-1:0] tx_slot;
    logic [IDX_W-1:0]  tx_idx;
    logic              rx_hit;
    logic              rx_chan;
    logic [SLOT_W-1:0] rx_slot;
    logic [IDX_W-1:0]  rx_idx;

    asp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_in   (bclk_in),
        .lrclk_in  (lrclk_in),
        .bclk_fall (bclk_fall),
        .bclk_rise (bclk_rise),
        .lr_lvl    (lr_lvl)
    );

    asp_frame_ctr #(.POS_W(POS_W)) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_fall   (bclk_fall),
        .lr_lvl      (lr_lvl),
        .fmt_sel     (fmt_sel),
        .pos_q       (pos_q),
        .pos_nx      (pos_nx),
        .half_q      (half_q),
        .frame_start (frame_start)
    );

    asp_slot_map #(
        .SAMPLE_W(SAMPLE_W), .SLOTS(SLOTS), .HALF_BCLK(HALF_BCLK),
        .PACK_HALF_BCLK(PACK_HALF_BCLK), .POS_W(POS_W)
    ) u_tx_map (
        .fmt_sel  (fmt_sel),
        .wlen_sel (wlen_sel),
        .pos      (pos_nx),
        .half     (lr_lvl),
        .hit      (tx_hit),
        .chan     (tx_chan),
        .slot     (tx_slot),
        .bit_idx  (tx_idx)
    );

    asp_slot_map #(
        .SAMPLE_W(SAMPLE_W), .SLOTS(SLOTS), .HALF_BCLK(HALF_BCLK),
        .PACK_HALF_BCLK(PACK_HALF_BCLK), .POS_W(POS_W)
    ) u_rx_map (
        .fmt_sel  (fmt_sel),
        .wlen_sel (wlen_sel),
        .pos      (pos_q),
        .half     (half_q),
        .hit      (rx_hit),
        .chan     (rx_chan),
        .slot     (rx_slot),
        .bit_idx  (rx_idx)
    );

    asp_tx #(.SAMPLE_W(SAMPLE_W), .SLOTS(SLOTS)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_fall   (bclk_fall),
        .frame_start (frame_start),
        .hit         (tx_hit),
        .chan        (tx_chan),
        .slot        (tx_slot),
        .bit_idx     (tx_idx),
        .tx_left     (tx_left),
        .tx_right    (tx_right),
        .sd_out      (sd_out)
    );

    asp_rx #(.SAMPLE_W(SAMPLE_W), .SLOTS(SLOTS)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .bclk_rise   (bclk_rise),
        .frame_start (frame_start),
        .hit         (rx_hit),
        .chan        (rx_chan),
        .slot        (rx_slot),
        .bit_idx     (rx_idx),
        .sd_in       (sd_in),
        .rx_left     (rx_left),
        .rx_right    (rx_right),
        .rx_strobe   (rx_strobe)
    );

endmodule

// File: rtl/asp_checker.sv
// Assertion checker for the audio serial port, bound to the top module.
// Observes edge strobes, frame start, the transmit map hit and the ports.
module asp_checker #(
    parameter int BUS_W = 96
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bclk_fall,
    input logic             frame_start,
    input logic             tx_hit,
    input logic             sd_out,
    input logic             rx_strobe,
    input logic [BUS_W-1:0] rx_left,
    input logic [BUS_W-1:0] rx_right
);

    // R9
    tx_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bclk_fall) |-> $stable(sd_out));

    // R8
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bclk_fall) && !$past(tx_hit)) |-> !sd_out);

    // R10
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |=> !rx_strobe);

    // R10
    strobe_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |-> $past(frame_start));

    // R10
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_strobe |-> ($stable(rx_left) && $stable(rx_right)));

endmodule

bind audio_serial_port asp_checker #(.BUS_W(BUS_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bclk_fall   (bclk_fall),
    .frame_start (frame_start),
    .tx_hit      (tx_hit),
    .sd_out      (sd_out),
    .rx_strobe   (rx_strobe),
    .rx_left     (rx_left),
    .rx_right    (rx_right)
);

// File: tb/audio_serial_port_tb.sv
module audio_serial_port_tb;

    localparam int BUS_W = 96;
    localparam int NVEC  = 10;

    // {fmt_sel, wlen_sel, expected width in bits}
    localparam logic [9:0] VECS [NVEC] = '{
        {3'b000, 2'b00, 5'd24},
        {3'b001, 2'b00, 5'd24},
        {3'b010, 2'b00, 5'd24},
        {3'b010, 2'b10, 5'd16},
        {3'b011, 2'b01, 5'd20},
        {3'b100, 2'b00, 5'd24},
        {3'b000, 2'b01, 5'd20},
        {3'b001, 2'b11, 5'd24},
        {3'b110, 2'b10, 5'd16},
        {3'b100, 2'b10, 5'd16}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       fmt_sel = 3'b000;
    logic [1:0]       wlen_sel = 2'b00;
    logic             bclk = 1'b1;
    logic             lrclk = 1'b1;
    logic [BUS_W-1:0] tx_left = '0;
    logic [BUS_W-1:0] tx_right = '0;
    logic             sd_out;
    logic [BUS_W-1:0] rx_left;
    logic [BUS_W-1:0] rx_right;
    logic             rx_strobe;

    logic [BUS_W-1:0] ref_l;
    logic [BUS_W-1:0] ref_r;
    int               errors = 0;
    int               checks = 0;
    int               strobes = 0;

    always #4 clk = ~clk;

    audio_serial_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .fmt_sel   (fmt_sel),
        .wlen_sel  (wlen_sel),
        .bclk_in   (bclk),
        .lrclk_in  (lrclk),
        .tx_left   (tx_left),
        .tx_right  (tx_right),
        .sd_out    (sd_out),
        .sd_in     (sd_out),
        .rx_left   (rx_left),
        .rx_right  (rx_right),
        .rx_strobe (rx_strobe)
    );

    always @(negedge clk) if (rx_strobe) strobes++;

    task automatic check(input bit ok, input string tag,
                         input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected line value at frame position fp, from the requirements
    function automatic logic exp_bit(input logic [2:0] f, input int w, input int fp);
        int hf, hp, st, k, sl;
        logic [23:0] word;
        if (f == 3'b100) begin
            hf = fp / 128; hp = fp % 128; sl = hp / 32; k = hp % 32;
            word = hf != 0 ? ref_r[sl*24 +: 24] : ref_l[sl*24 +: 24];
            return (k < w) ? word[23-k] : 1'b0;
        end
        if (f == 3'b011) begin
            k = fp - 1;
            if (k < 0 || k >= 2 * w) return 1'b0;
            if (k < w) return ref_l[23-k];
            return ref_r[23-(k-w)];
        end
        hf = fp / 32; hp = fp % 32;
        word = hf != 0 ? ref_r[23:0] : ref_l[23:0];
        st = (f == 3'b001) ? 0 : (f == 3'b010) ? 32 - w : 1;
        k = hp - st;
        return (k >= 0 && k < w) ? word[23-k] : 1'b0;
    endfunction

    function automatic string tag_of(input logic [2:0] f, input int w);
        string t;
        case (f)
            3'b000:  t = "R2";
            3'b001:  t = "R3";
            3'b010:  t = "R4";
            3'b011:  t = "R5";
            3'b100:  t = "R6";
            default: t = "R12";
        endcase
        if (w != 24) t = {t, "/R7/R8"};
        return t;
    endfunction

    // one idle bit clock that sets up the word-clock edge of the next frame
    task automatic preamble(input logic [2:0] f);
        @(negedge clk);
        bclk = 1'b0;
        lrclk = (f == 3'b011) ? 1'b0 : 1'b1;
        repeat (7) @(negedge clk);
        bclk = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    // drive one frame; count wrong bits and bits that moved in the high phase
    task automatic run_frame(input logic [2:0] f, input int w, input bit tamper,
                             output int bad, output int moved);
        int fl;
        logic s1, s2;
        fl = (f == 3'b100) ? 256 : 64;
        bad = 0; moved = 0;
        for (int fp = 0; fp < fl; fp++) begin
            @(negedge clk);
            bclk = 1'b0;
            lrclk = (f == 3'b011) ? (fp == 0) : (fp >= fl / 2);
            if (tamper && fp == 40) begin
                tx_left = ~ref_l;
                tx_right = ~ref_r;
            end
            repeat (7) @(negedge clk);
            bclk = 1'b1;
            repeat (4) @(negedge clk);
            s1 = sd_out;
            repeat (3) @(negedge clk);
            s2 = sd_out;
            if (s1 !== exp_bit(f, w, fp)) bad++;
            if (s2 !== s1) moved++;
        end
    endtask

    task automatic load_words(input int vi);
        for (int k = 0; k < 4; k++) begin
            ref_l[k*24 +: 24] = 24'hC35A96 ^ 24'(vi * 24'h0A1B3) ^ 24'(k * 24'h111111);
            ref_r[k*24 +: 24] = 24'h5E71B2 ^ 24'(vi * 24'h13579) ^ 24'(k * 24'h0F0F0F);
        end
        tx_left = ref_l;
        tx_right = ref_r;
    endtask

    initial begin
        int bad, moved, w, s0;
        logic [2:0] f;
        logic [23:0] m;
        logic [BUS_W-1:0] el, er;

        // reset state
        repeat (5) @(negedge clk);
        check(sd_out == 1'b0 && rx_strobe == 1'b0, "R1 outputs in reset",
              BUS_W'({sd_out, rx_strobe}), '0);
        check(rx_left == '0 && rx_right == '0, "R1 words in reset", rx_left | rx_right, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sd_out == 1'b0 && rx_strobe == 1'b0, "R1 first cycle after reset",
              BUS_W'({sd_out, rx_strobe}), '0);

        // table walk: two frames per entry, serial bits then loopback words
        for (int vi = 0; vi < NVEC; vi++) begin
            f = VECS[vi][9:7];
            w = int'(VECS[vi][4:0]);
            fmt_sel = f;
            wlen_sel = VECS[vi][6:5];
            load_words(vi);
            preamble(f);
            run_frame(f, w, 1'b0, bad, moved);
            check(bad == 0, {tag_of(f, w), " serial frame"}, BUS_W'(bad), '0);
            check(moved == 0, "R9 line held in high phase", BUS_W'(moved), '0);
            s0 = strobes;
            run_frame(f, w, 1'b0, bad, moved);
            check(bad == 0, {tag_of(f, w), " repeat frame"}, BUS_W'(bad), '0);
            m = '1;
            m = m << (24 - w);
            el = '0; er = '0;
            for (int k = 0; k < 4; k++) begin
                if (f == 3'b100 || k == 0) begin
                    el[k*24 +: 24] = ref_l[k*24 +: 24] & m;
                    er[k*24 +: 24] = ref_r[k*24 +: 24] & m;
                end
            end
            check(rx_left == el, "R10 left loopback", rx_left, el);
            check(rx_right == er, "R10 right loopback", rx_right, er);
            check(strobes - s0 == 1, "R10 one strobe per frame", BUS_W'(strobes - s0), 96'd1);
        end

        // inputs changed mid-frame must not reach the line (left-justified, 24 bits)
        fmt_sel = 3'b001;
        wlen_sel = 2'b00;
        load_words(3);
        preamble(3'b001);
        run_frame(3'b001, 24, 1'b1, bad, moved);
        check(bad == 0, "R11 mid-frame input change ignored", BUS_W'(bad), '0);

        // reset during operation clears everything
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(sd_out == 1'b0 && rx_strobe == 1'b0 && rx_left == '0 && rx_right == '0,
              "R1 reset mid-run", rx_left | rx_right, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule